// File: doc/BRIEF.md
# Multi-FIFO Inter-Processor Mailbox

This block is a memory-mapped mailbox that lets several processors exchange 32-bit messages. It holds a parameterised number of four-entry message queues and a parameterised number of users. Each user owns one interrupt line. Any processor can push a message into a queue by writing that queue's message register. The receiver pops the message by reading the same register. Per-queue count and full registers let software poll a queue instead of waiting for an interrupt.

Each user has a status word and an enable word. Both carry two events per queue: one says the queue holds messages, and one says it has room. A user's interrupt line is raised while any status bit is set whose enable bit is also set. A compile-time parameter picks one of two register layouts for the interrupt registers. In layout 1, each user has one read/write enable register. In layout 2, each user has separate registers that set and clear enable bits.

Top module: `ipc_mailbox`

## Requirements
- R1: After synchronous active-low reset, every queue is empty, every status and enable bit is zero, and every interrupt line is low.
- R2: Offset 0x000 reads the REVISION parameter value. Writes to it have no effect.
- R3: A write to the message register of queue m, at 0x040 + 4*m, appends the 32-bit data. A read of that register returns and removes the oldest entry. The register at 0x0C0 + 4*m reads the number of entries held in queue m.
- R4: The register at 0x080 + 4*m reads 1 when queue m holds DEPTH entries and 0 otherwise. A write to a full queue is dropped and leaves its contents unchanged.
- R5: A read of the message register of an empty queue returns zero and leaves the queue empty.
- R6: In every user's status and enable words, bit 2*m is the new-message event of queue m and bit 2*m+1 is the not-full event of queue m. On every clock where the queue is non-empty, the new-message bit is set on the next edge. On every clock where the queue is not full, the not-full bit is set on the next edge.
- R7: Writing a one to a status bit clears it, but only when that bit's condition is false at that clock. Bits written with zero are unchanged.
- R8: In layout 1 (LAYOUT=1), user u's status is at 0x100 + 8*u. Its enable word is at 0x104 + 8*u; a write there replaces the whole enable word, and a read returns it.
- R9: In layout 2 (LAYOUT=2), user u's status is at 0x104 + 0x10*u. Ones written to 0x108 + 0x10*u set enable bits, and ones written to 0x10C + 0x10*u clear them. Zero bits written to either register leave the enable word unchanged. Both registers read back the enable word, and offset 0x100 is unmapped.
- R10: User u's interrupt line is high exactly when the bitwise AND of its status and enable words is nonzero.
- R11: Unmapped or unaligned addresses read as zero and ignore writes. This includes queue and user indices at or above N_FIFO or N_USER.
- R12: Read data is registered: it changes only on the clock edge that samples a read strobe, and it then holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_rd | input | 1 | Single-cycle read strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | N_USER | One interrupt line per user |

## Verification
On every clock, the embedded assertions check four things: queue counts on dropped and accepted pushes and on empty pops, that each live event condition sets its status bit on the next edge, that write-one-to-clear removes bits whose condition is idle, and the enable update rules of the selected layout. They also check that read data stays stable between reads and is zero after a read of an unmapped address. Only the directed scenarios can show message ordering, the revision value, the exact bit positions seen at the register addresses, interrupt rise and fall through whole write/enable sequences, and the layout-2 address map on a second instance.

// File: rtl/mbox_pkg.sv
// Package: mbox_pkg
// Shared register-kind encoding used by the mailbox address decoder and top.
// Assumes a 32-bit data bus and byte addressing.
package mbox_pkg;

    typedef enum logic [3:0] {
        K_NONE  = 4'd0,
        K_REV   = 4'd1,
        K_MSG   = 4'd2,
        K_FSTAT = 4'd3,
        K_MSTAT = 4'd4,
        K_ISTAT = 4'd5,
        K_IEN   = 4'd6,
        K_ISET  = 4'd7,
        K_ICLR  = 4'd8
    } reg_kind_e;

    localparam int DATA_W = 32;

endpackage

// File: rtl/mbox_fifo.sv
// Module: mbox_fifo
// One message queue of DEPTH words. A push to a full queue is dropped, and a
// pop of an empty queue changes nothing. The head output is zero while empty.
// Assumes push and pop are single-cycle strobes.
module mbox_fifo #(
    parameter int DEPTH = 4,
    parameter int DW    = 32,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] head,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);

    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] wptr, rptr;
    logic          push_ok, pop_ok;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign head    = empty ? '0 : mem[rptr];

    function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (push_ok) wptr <= nxt(wptr);
            if (pop_ok)  rptr <= nxt(rptr);
            if (push_ok && !pop_ok)      count <= count + 1'b1;
            else if (pop_ok && !push_ok) count <= count - 1'b1;
        end
    end

    // Storage write; contents need no reset.
    always_ff @(posedge clk) begin
        if (push_ok) mem[wptr] <= wdata;
    end

    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop) |=> (count == CW'(DEPTH)));

    assert_empty_pop_noop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !push) |=> (count == '0));

    assert_push_counts_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !full && !pop) |=> (count == CW'($past(count) + 1'b1)));

endmodule

// File: rtl/mbox_addr_decode.sv
// Module: mbox_addr_decode
// Maps a byte address onto a register kind, a queue index and a user index.
// LAYOUT picks the interrupt register map (1: status+enable pairs at 8-byte
// stride; 2: status/set/clear at 16-byte stride). Assumes ADDR_W >= 12.
module mbox_addr_decode
    import mbox_pkg::*;
#(
    parameter int N_FIFO = 4,
    parameter int N_USER = 2,
    parameter int LAYOUT = 1,
    parameter int ADDR_W = 12,
    localparam int FW    = (N_FIFO > 1) ? $clog2(N_FIFO) : 1,
    localparam int UW    = (N_USER > 1) ? $clog2(N_USER) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_kind_e         kind,
    output logic [FW-1:0]     fifo_idx,
    output logic [UW-1:0]     user_idx
);

    logic [ADDR_W-1:0] off1, off2, u1, u2;
    logic [4:0]        fsel;

    assign off1 = addr - ADDR_W'(12'h100);
    assign off2 = addr - ADDR_W'(12'h104);
    assign u1   = off1 >> 3;
    assign u2   = off2 >> 4;
    assign fsel = {1'b0, addr[5:2]};

    // Kind and index selection.
    always_comb begin
        kind     = K_NONE;
        fifo_idx = addr[2 +: FW];
        user_idx = '0;
        if (addr[1:0] != 2'b00) begin
            kind = K_NONE;
        end else if (addr < ADDR_W'(12'h100)) begin
            unique case (addr[7:6])
                2'd0: kind = (addr[5:2] == 4'd0) ? K_REV : K_NONE;
                2'd1: kind = (fsel < 5'(N_FIFO)) ? K_MSG : K_NONE;
                2'd2: kind = (fsel < 5'(N_FIFO)) ? K_FSTAT : K_NONE;
                default: kind = (fsel < 5'(N_FIFO)) ? K_MSTAT : K_NONE;
            endcase
        end else if (LAYOUT == 1) begin
            user_idx = u1[UW-1:0];
            if (u1 < ADDR_W'(N_USER))
                kind = off1[2] ? K_IEN : K_ISTAT;
        end else begin
            user_idx = u2[UW-1:0];
            if (addr >= ADDR_W'(12'h104) && u2 < ADDR_W'(N_USER)) begin
                unique case (off2[3:2])
                    2'd0: kind = K_ISTAT;
                    2'd1: kind = K_ISET;
                    2'd2: kind = K_ICLR;
                    default: kind = K_NONE;
                endcase
            end
        end
    end

endmodule

// File: rtl/mbox_user_irq.sv
// Module: mbox_user_irq
// One user's event status and enable words plus its interrupt line.
// Status bits are set by live queue conditions and cleared by writing one.
// Enable update follows LAYOUT (1: whole-word write, 2: set/clear by ones).
module mbox_user_irq #(
    parameter int N_FIFO = 4,
    parameter int LAYOUT = 1,
    localparam int EW    = 2 * N_FIFO
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_FIFO-1:0] fifo_nonempty,
    input  logic [N_FIFO-1:0] fifo_full,
    input  logic              stat_w1c_we,
    input  logic              en_we,
    input  logic              en_set_we,
    input  logic              en_clr_we,
    input  logic [EW-1:0]     wdata,
    output logic [EW-1:0]     status_q,
    output logic [EW-1:0]     enable_q,
    output logic              irq
);

    logic [EW-1:0] cond;
    logic [EW-1:0] enable_d;

    // Interleave the two events of each queue.
    for (genvar m = 0; m < N_FIFO; m++) begin : g_evt
        assign cond[2*m]     = fifo_nonempty[m];
        assign cond[2*m + 1] = ~fifo_full[m];
    end

    // Next enable word for the selected layout.
    always_comb begin
        enable_d = enable_q;
        if (LAYOUT == 1) begin
            if (en_we) enable_d = wdata;
        end else begin
            if (en_set_we) enable_d = enable_d | wdata;
            if (en_clr_we) enable_d = enable_d & ~wdata;
        end
    end

    // Status and enable registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= '0;
            enable_q <= '0;
        end else begin
            status_q <= (status_q & ~(stat_w1c_we ? wdata : '0)) | cond;
            enable_q <= enable_d;
        end
    end

    assign irq = |(status_q & enable_q);

    assert_event_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_q & $past(cond)) == $past(cond)));

    assert_w1c_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        stat_w1c_we |=> ((status_q & $past(wdata) & ~$past(cond)) == '0));

    assert_l1_enable_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (LAYOUT == 1 && en_we) |=> (enable_q == $past(wdata)));

    assert_l2_enable_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (LAYOUT == 2 && en_set_we && !en_clr_we) |=> ((enable_q & $past(wdata)) == $past(wdata)));

    assert_l2_enable_clr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (LAYOUT == 2 && en_clr_we) |=> ((enable_q & $past(wdata)) == '0));

    assert_irq_needs_enable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_q == '0) |-> !irq);

endmodule

// File: rtl/ipc_mailbox.sv
// Module: ipc_mailbox
// Top of the inter-processor mailbox: address decode, N_FIFO message queues,
// N_USER interrupt units and the registered read mux.
// Assumes N_FIFO <= 16, at most one access per queue register per cycle.
module ipc_mailbox
    import mbox_pkg::*;
#(
    parameter int          N_FIFO   = 4,
    parameter int          N_USER   = 2,
    parameter int          DEPTH    = 4,
    parameter int          LAYOUT   = 1,
    parameter int          ADDR_W   = 12,
    parameter logic [31:0] REVISION = 32'h4D42_0102,
    localparam int         FW       = (N_FIFO > 1) ? $clog2(N_FIFO) : 1,
    localparam int         UW       = (N_USER > 1) ? $clog2(N_USER) : 1,
    localparam int         CW       = $clog2(DEPTH + 1),
    localparam int         EW       = 2 * N_FIFO
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [N_USER-1:0] irq
);

    reg_kind_e     kind;
    logic [FW-1:0] fifo_idx;
    logic [UW-1:0] user_idx;

    logic [31:0]       head  [N_FIFO];
    logic [CW-1:0]     cnt   [N_FIFO];
    logic [N_FIFO-1:0] full_v, empty_v;
    logic [EW-1:0]     stat  [N_USER];
    logic [EW-1:0]     enab  [N_USER];
    logic [31:0]       rd_val;

    mbox_addr_decode #(
        .N_FIFO (N_FIFO),
        .N_USER (N_USER),
        .LAYOUT (LAYOUT),
        .ADDR_W (ADDR_W)
    ) u_dec (
        .addr     (bus_addr),
        .kind     (kind),
        .fifo_idx (fifo_idx),
        .user_idx (user_idx)
    );

    for (genvar m = 0; m < N_FIFO; m++) begin : g_fifo
        logic hit;
        assign hit = (kind == K_MSG) && (fifo_idx == FW'(m));
        mbox_fifo #(.DEPTH(DEPTH), .DW(32)) u_fifo (
            .clk   (clk),
            .rst_n (rst_n),
            .push  (bus_wr && hit),
            .pop   (bus_rd && hit),
            .wdata (bus_wdata),
            .head  (head[m]),
            .count (cnt[m]),
            .full  (full_v[m]),
            .empty (empty_v[m])
        );
    end

    for (genvar u = 0; u < N_USER; u++) begin : g_user
        logic uhit;
        assign uhit = (user_idx == UW'(u));
        mbox_user_irq #(.N_FIFO(N_FIFO), .LAYOUT(LAYOUT)) u_irq (
            .clk           (clk),
            .rst_n         (rst_n),
            .fifo_nonempty (~empty_v),
            .fifo_full     (full_v),
            .stat_w1c_we   (bus_wr && uhit && kind == K_ISTAT),
            .en_we         (bus_wr && uhit && kind == K_IEN),
            .en_set_we     (bus_wr && uhit && kind == K_ISET),
            .en_clr_we     (bus_wr && uhit && kind == K_ICLR),
            .wdata         (bus_wdata[EW-1:0]),
            .status_q      (stat[u]),
            .enable_q      (enab[u]),
            .irq           (irq[u])
        );
    end

    // Read value selection for the addressed register.
    always_comb begin
        unique case (kind)
            K_REV:                 rd_val = REVISION;
            K_MSG:                 rd_val = head[fifo_idx];
            K_FSTAT:               rd_val = {31'd0, full_v[fifo_idx]};
            K_MSTAT:               rd_val = 32'(cnt[fifo_idx]);
            K_ISTAT:               rd_val = 32'(stat[user_idx]);
            K_IEN, K_ISET, K_ICLR: rd_val = 32'(enab[user_idx]);
            default:               rd_val = '0;
        endcase
    end

    // Registered read data, updated only on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_val;
    end

    assert_unmapped_reads_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && kind == K_NONE) |=> (bus_rdata == '0));

    assert_rdata_holds_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));

endmodule

// File: tb/ipc_mailbox_bench.sv
// Directed bench: instance A uses layout 1 (4 queues, 2 users), instance B
// uses layout 2 (2 queues, 2 users). Each task checks its own results.
module ipc_mailbox_bench;

    localparam logic [31:0] REV = 32'h1234_5678;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        a_wr = 0, a_rd = 0, b_wr = 0, b_rd = 0;
    logic [11:0] a_addr = '0, b_addr = '0;
    logic [31:0] a_wdata = '0, b_wdata = '0;
    logic [31:0] a_rdata, b_rdata;
    logic [1:0]  a_irq, b_irq;
    int          n_chk = 0, n_bad = 0;
    bit          done = 0;

    always #2.5 clk = ~clk;

    ipc_mailbox #(.N_FIFO(4), .N_USER(2), .DEPTH(4), .LAYOUT(1), .REVISION(REV)) u_ipc_mailbox (
        .clk(clk), .rst_n(rst_n), .bus_wr(a_wr), .bus_rd(a_rd), .bus_addr(a_addr),
        .bus_wdata(a_wdata), .bus_rdata(a_rdata), .irq(a_irq));

    ipc_mailbox #(.N_FIFO(2), .N_USER(2), .DEPTH(4), .LAYOUT(2), .REVISION(REV)) u_ipc_mailbox_alt (
        .clk(clk), .rst_n(rst_n), .bus_wr(b_wr), .bus_rd(b_rd), .bus_addr(b_addr),
        .bus_wdata(b_wdata), .bus_rdata(b_rdata), .irq(b_irq));

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
        end
    endtask

    task automatic wr(input bit b, input logic [11:0] ad, input logic [31:0] d);
        @(negedge clk);
        if (b) begin b_wr = 1; b_addr = ad; b_wdata = d; end
        else   begin a_wr = 1; a_addr = ad; a_wdata = d; end
        @(negedge clk);
        a_wr = 0; b_wr = 0;
    endtask

    task automatic rd(input bit b, input logic [11:0] ad, output logic [31:0] d);
        @(negedge clk);
        if (b) begin b_rd = 1; b_addr = ad; end
        else   begin a_rd = 1; a_addr = ad; end
        @(negedge clk);
        a_rd = 0; b_rd = 0;
        d = b ? b_rdata : a_rdata;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        chk("R1 irq A", {30'd0, a_irq}, 32'd0);
        chk("R1 irq B", {30'd0, b_irq}, 32'd0);
        for (int m = 0; m < 4; m++) begin
            rd(0, 12'h0C0 + 12'(4*m), v); chk("R1 count", v, 0);
        end
        rd(0, 12'h104, v); chk("R1 enable u0", v, 0);
        rd(0, 12'h100, v); chk("R6 not-full bits after reset", v, 32'hAA);
    endtask

    task automatic t_revision();
        logic [31:0] v;
        rd(0, 12'h000, v); chk("R2 revision", v, REV);
        wr(0, 12'h000, 32'hFFFF_FFFF);
        rd(0, 12'h000, v); chk("R2 revision after write", v, REV);
    endtask

    task automatic t_order();
        logic [31:0] v;
        wr(0, 12'h044, 32'hA1); wr(0, 12'h044, 32'hB2); wr(0, 12'h044, 32'hC3);
        rd(0, 12'h0C4, v); chk("R3 count 3", v, 3);
        rd(0, 12'h044, v); chk("R3 first", v, 32'hA1);
        rd(0, 12'h044, v); chk("R3 second", v, 32'hB2);
        rd(0, 12'h044, v); chk("R3 third", v, 32'hC3);
        rd(0, 12'h0C4, v); chk("R3 count 0", v, 0);
    endtask

    task automatic t_full();
        logic [31:0] v;
        for (int i = 0; i < 5; i++) wr(0, 12'h048, 32'h100 + 32'(i));
        rd(0, 12'h088, v); chk("R4 full flag", v, 1);
        rd(0, 12'h0C8, v); chk("R4 count at depth", v, 4);
        for (int i = 0; i < 4; i++) begin
            rd(0, 12'h048, v); chk("R4 kept entry", v, 32'h100 + 32'(i));
        end
        rd(0, 12'h088, v); chk("R4 full flag cleared", v, 0);
    endtask

    task automatic t_empty();
        logic [31:0] v;
        rd(0, 12'h04C, v); chk("R5 empty read", v, 0);
        rd(0, 12'h0CC, v); chk("R5 count stays 0", v, 0);
    endtask

    task automatic t_events();
        logic [31:0] v;
        wr(0, 12'h100, 32'hFF);
        rd(0, 12'h100, v); chk("R7 w1c clears idle bits", v, 32'hAA);
        wr(0, 12'h040, 32'h55);
        rd(0, 12'h100, v); chk("R6 new-message bit0", v, 32'hAB);
        wr(0, 12'h100, 32'h03);
        rd(0, 12'h100, v); chk("R7 w1c ignored while condition live", v, 32'hAB);
        wr(0, 12'h100, 32'h00);
        rd(0, 12'h100, v); chk("R7 zeros no effect", v, 32'hAB);
        rd(0, 12'h040, v); chk("R3 pop", v, 32'h55);
        wr(0, 12'h100, 32'h01);
        rd(0, 12'h100, v); chk("R7 w1c after drain", v, 32'hAA);
    endtask

    task automatic t_irq_l1();
        logic [31:0] v;
        wr(0, 12'h104, 32'h01);
        rd(0, 12'h104, v); chk("R8 enable readback", v, 32'h01);
        chk("R10 irq0 low, no event", {31'd0, a_irq[0]}, 0);
        wr(0, 12'h040, 32'h77);
        repeat (2) @(negedge clk);
        chk("R10 irq0 high", {31'd0, a_irq[0]}, 1);
        chk("R10 irq1 low", {31'd0, a_irq[1]}, 0);
        wr(0, 12'h10C, 32'h02);
        @(negedge clk);
        chk("R10 irq1 on not-full", {31'd0, a_irq[1]}, 1);
        wr(0, 12'h104, 32'h04);
        rd(0, 12'h104, v); chk("R8 enable replaced", v, 32'h04);
        chk("R10 irq0 low after replace", {31'd0, a_irq[0]}, 0);
        rd(0, 12'h040, v);
        wr(0, 12'h104, 0); wr(0, 12'h10C, 0);
        @(negedge clk);
        chk("R10 irq lines low", {30'd0, a_irq}, 0);
    endtask

    task automatic t_unmapped();
        logic [31:0] v;
        wr(0, 12'h050, 32'hDEAD);
        rd(0, 12'h050, v); chk("R11 queue index 4", v, 0);
        for (int m = 0; m < 4; m++) begin
            rd(0, 12'h0C0 + 12'(4*m), v); chk("R11 counts untouched", v, 0);
        end
        rd(0, 12'h041, v); chk("R11 unaligned", v, 0);
        rd(0, 12'h110, v); chk("R11 user index 2", v, 0);
    endtask

    task automatic t_rdata_timing();
        logic [31:0] v;
        rd(0, 12'h0C0, v); chk("R12 prior read", v, 0);
        @(negedge clk);
        a_rd = 1; a_addr = 12'h000;
        #1;
        chk("R12 held before edge", a_rdata, 0);
        @(negedge clk);
        a_rd = 0;
        chk("R12 updated after edge", a_rdata, REV);
        repeat (2) @(negedge clk);
        chk("R12 held without strobe", a_rdata, REV);
    endtask

    task automatic t_layout2();
        logic [31:0] v;
        rd(1, 12'h104, v); chk("R9 status u0", v, 32'h0A);
        rd(1, 12'h100, v); chk("R9 0x100 unmapped", v, 0);
        wr(1, 12'h108, 32'h03);
        rd(1, 12'h108, v); chk("R9 set readback", v, 32'h03);
        rd(1, 12'h10C, v); chk("R9 clear readback", v, 32'h03);
        wr(1, 12'h108, 32'h00);
        wr(1, 12'h10C, 32'h00);
        rd(1, 12'h108, v); chk("R9 zeros no change", v, 32'h03);
        wr(1, 12'h10C, 32'h01);
        rd(1, 12'h108, v); chk("R9 clear bit0", v, 32'h02);
        chk("R10 irq B0 on not-full", {31'd0, b_irq[0]}, 1);
        wr(1, 12'h10C, 32'h02);
        @(negedge clk);
        chk("R10 irq B0 off", {31'd0, b_irq[0]}, 0);
        wr(1, 12'h044, 32'h99);
        rd(1, 12'h114, v); chk("R9 user1 status", v, 32'h0E);
        chk("R10 irq B1 low", {31'd0, b_irq[1]}, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_revision();
        t_order();
        t_full();
        t_empty();
        t_events();
        t_irq_l1();
        t_unmapped();
        t_rdata_timing();
        t_layout2();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule